// File: doc/BRIEF.md
# On-Demand Masking Randomness Source

This block supplies fresh random bits to a masked datapath that spends randomness in bursts. Two 128-bit pseudo-random generators run side by side. Each is a maximum-length linear feedback shift register with XNOR feedback, so its all-zero state is a legal seed and its all-ones state is the one it locks in. The generators stay still until the consumer asks for randomness. A request makes them advance a configured number of steps. Only after those steps does the block show a fresh random word as valid. Until then the consumer is stalled through its state-enable, so its registers keep their values.

Seeds arrive as 32-bit words on a shared feed port, each word marked as seed material. Eight seed words fill both generators, four words each. Any seed word discards the word currently on offer, so stale randomness is never handed out after reseeding. The same controller also carries the start and done handshake between an outer sequencer and the datapath, and it keeps a busy flag between the two.

Top module: `rnd_src_top`

## Requirements
- R1: After reset, rnd_valid is 0, core_en is 1, ctl_busy, core_start and ctl_done are 0, and rnd_data is 0 (both generators reset to the all-zero state).
- R2: Each feed word with feed_valid=1 and feed_is_seed=1 is a seed word. Seed word k (k = 0..7, counted from reset and wrapping after 7) goes to generator k/4, into its state bits [32*(k%4)+31 : 32*(k%4)]. rnd_data is {generator 1 state[31:0], generator 0 state[31:0]}.
- R3: Feed words with feed_is_seed=0 change neither generator and do not advance the seed word count.
- R4: A seed word clears rnd_valid on the next edge and restarts the step count. No generator steps in a cycle in which a seed word is written.
- R5: The generators hold their state in every cycle without a pending request (rnd_req=0, or rnd_valid=1).
- R6: With rnd_req held high from a cycle in which rnd_valid=0, the generators advance once per cycle. rnd_valid rises exactly RND_STEPS (default 4) cycles later.
- R7: core_en is 0 exactly in the cycles in which rnd_req=1 and rnd_valid=0, and it is 1 otherwise.
- R8: rnd_valid and rnd_data hold while rnd_ack is 0. rnd_ack with rnd_valid=1 clears rnd_valid on the next edge, so every new word needs RND_STEPS fresh steps and no word is delivered twice.
- R9: One step maps state s to {s[126:0], ~(s[127]^s[125]^s[100]^s[98])}, and the all-zero state steps to 1.
- R10: A ctl_start pulse while not busy gives a one-cycle core_start on the next edge and sets ctl_busy. ctl_start while busy is ignored. ctl_done equals core_done while busy, and core_done clears ctl_busy on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| feed_valid | input | 1 | Feed word present |
| feed_is_seed | input | 1 | Feed word is seed material |
| feed_data | input | 32 | Feed word |
| rnd_req | input | 1 | Consumer needs randomness |
| rnd_ack | input | 1 | Consumer has used the offered word |
| rnd_valid | output | 1 | Offered random word is fresh |
| rnd_data | output | 64 | Random word, 32 bits from each generator |
| core_en | output | 1 | State-enable to the consumer, low while stalled |
| ctl_start | input | 1 | Start request from the outer sequencer |
| ctl_busy | output | 1 | Datapath run in progress |
| ctl_done | output | 1 | Completion passed to the outer sequencer |
| core_start | output | 1 | Start pulse to the datapath |
| core_done | input | 1 | Completion from the datapath |

## Verification
A wrong generator state shows on rnd_data as soon as the next word becomes valid, which is RND_STEPS cycles after a request. The bench compares every delivered word with its own model of the feedback polynomial, so a wrong tap, a wrong lane or a lost seed word is caught on the first fetch after seeding. A wrong step counter or ready flag shows at once as a stall that is too short or too long on core_en and as a valid that rises on the wrong cycle. A ready flag stuck high shows as a repeated word, which the bench rejects by comparing each word with all words delivered before it.

// File: rtl/rnd_src_pkg.sv
package rnd_src_pkg;

    localparam int LFSR_W        = 128;
    localparam int WORD_W        = 32;
    localparam int NUM_GEN       = 2;
    localparam int WORDS_PER_GEN = LFSR_W / WORD_W;
    localparam int SEED_WORDS    = NUM_GEN * WORDS_PER_GEN;
    localparam int SEED_IDX_W    = $clog2(SEED_WORDS);
    localparam int LANE_W        = $clog2(WORDS_PER_GEN);
    localparam int GEN_W         = $clog2(NUM_GEN);

    // zero-based tap positions of the feedback polynomial
    localparam int TAP_A = 127;
    localparam int TAP_B = 125;
    localparam int TAP_C = 100;
    localparam int TAP_D = 98;

    typedef logic [LFSR_W-1:0] lfsr_state_t;

    typedef struct packed {
        logic [NUM_GEN-1:0] gen_sel;
        logic [LANE_W-1:0]  lane;
        logic [WORD_W-1:0]  word;
    } seed_wr_t;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_READY = 1'b1
    } rnd_state_e;

    function automatic lfsr_state_t lfsr_advance(input lfsr_state_t s);
        logic fb;
        fb = ~(s[TAP_A] ^ s[TAP_B] ^ s[TAP_C] ^ s[TAP_D]);
        return {s[LFSR_W-2:0], fb};
    endfunction

endpackage

// File: rtl/rnd_lfsr_gen.sv
module rnd_lfsr_gen
    import rnd_src_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [WORD_W-1:0] word,
    input  logic              step,
    output logic [OUT_W-1:0]  rnd_word
);

    lfsr_state_t state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (wr_en) begin
            state_q[lane*WORD_W +: WORD_W] <= word;
        end else if (step) begin
            state_q <= lfsr_advance(state_q);
        end
    end

    assign rnd_word = state_q[OUT_W-1:0];

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !step) |=> $stable(state_q));

    assert_shift_R9: assert property (@(posedge clk) disable iff (rst)
        (step && !wr_en) |=> (state_q[LFSR_W-1:1] == $past(state_q[LFSR_W-2:0])));

endmodule

// File: rtl/rnd_seed_loader.sv
module rnd_seed_loader
    import rnd_src_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              feed_valid,
    input  logic              feed_is_seed,
    input  logic [WORD_W-1:0] feed_data,
    output seed_wr_t          seed_wr,
    output logic              seed_any
);

    logic [SEED_IDX_W-1:0] idx_q;
    logic                  take;

    assign take = feed_valid && feed_is_seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_sel
        assign seed_wr.gen_sel[g] = take && (idx_q[SEED_IDX_W-1:LANE_W] == GEN_W'(g));
    end

    assign seed_wr.lane = idx_q[LANE_W-1:0];
    assign seed_wr.word = feed_data;
    assign seed_any     = take;

    assert_idx_R3: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(idx_q));

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(seed_wr.gen_sel));

endmodule

// File: rtl/rnd_stall_ctrl.sv
module rnd_stall_ctrl
    import rnd_src_pkg::*;
#(
    parameter int RND_STEPS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic seed_any,
    input  logic rnd_req,
    input  logic rnd_ack,
    output logic lfsr_step,
    output logic rnd_valid,
    output logic core_en,
    input  logic ctl_start,
    input  logic core_done,
    output logic core_start,
    output logic ctl_busy,
    output logic ctl_done
);

    localparam int CNT_W = $clog2(RND_STEPS + 1);

    rnd_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;

    assign lfsr_step = rnd_req && (st_q == RS_EMPTY) && !seed_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RS_EMPTY;
            cnt_q <= '0;
        end else if (seed_any) begin
            st_q  <= RS_EMPTY;
            cnt_q <= '0;
        end else if (lfsr_step) begin
            if (cnt_q == CNT_W'(RND_STEPS - 1)) begin
                st_q  <= RS_READY;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (st_q == RS_READY && rnd_ack) begin
            st_q <= RS_EMPTY;
        end
    end

    assign rnd_valid = (st_q == RS_READY);
    assign core_en   = !(rnd_req && st_q == RS_EMPTY);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_busy   <= 1'b0;
            core_start <= 1'b0;
        end else begin
            core_start <= ctl_start && !ctl_busy;
            if (ctl_start && !ctl_busy) begin
                ctl_busy <= 1'b1;
            end else if (core_done) begin
                ctl_busy <= 1'b0;
            end
        end
    end

    assign ctl_done = core_done && ctl_busy;

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(RND_STEPS));

    assert_rise_after_step_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rnd_valid) |-> $past(lfsr_step));

    assert_seed_clears_R4: assert property (@(posedge clk) disable iff (rst)
        seed_any |=> !rnd_valid);

    assert_valid_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rnd_valid && !rnd_ack && !seed_any) |=> rnd_valid);

    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (rnd_valid && rnd_ack) |=> !rnd_valid);

    assert_no_step_ready_R5: assert property (@(posedge clk) disable iff (rst)
        rnd_valid |-> !lfsr_step);

    assert_busy_rise_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_busy) |-> core_start);

    assert_done_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl_busy && core_done) |=> !ctl_busy);

endmodule

// File: rtl/rnd_src_top.sv
module rnd_src_top
    import rnd_src_pkg::*;
#(
    parameter int RND_STEPS = 4,
    parameter int OUT_W     = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     feed_valid,
    input  logic                     feed_is_seed,
    input  logic [WORD_W-1:0]        feed_data,
    input  logic                     rnd_req,
    input  logic                     rnd_ack,
    output logic                     rnd_valid,
    output logic [NUM_GEN*OUT_W-1:0] rnd_data,
    output logic                     core_en,
    input  logic                     ctl_start,
    output logic                     ctl_busy,
    output logic                     ctl_done,
    output logic                     core_start,
    input  logic                     core_done
);

    seed_wr_t seed_wr;
    logic     seed_any;
    logic     lfsr_step;

    rnd_seed_loader u_seed (
        .clk          (clk),
        .rst          (rst),
        .feed_valid   (feed_valid),
        .feed_is_seed (feed_is_seed),
        .feed_data    (feed_data),
        .seed_wr      (seed_wr),
        .seed_any     (seed_any)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        rnd_lfsr_gen #(.OUT_W(OUT_W)) u_gen (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (seed_wr.gen_sel[g]),
            .lane     (seed_wr.lane),
            .word     (seed_wr.word),
            .step     (lfsr_step),
            .rnd_word (rnd_data[g*OUT_W +: OUT_W])
        );
    end

    rnd_stall_ctrl #(.RND_STEPS(RND_STEPS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .seed_any   (seed_any),
        .rnd_req    (rnd_req),
        .rnd_ack    (rnd_ack),
        .lfsr_step  (lfsr_step),
        .rnd_valid  (rnd_valid),
        .core_en    (core_en),
        .ctl_start  (ctl_start),
        .core_done  (core_done),
        .core_start (core_start),
        .ctl_busy   (ctl_busy),
        .ctl_done   (ctl_done)
    );

    assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (rnd_req && !rnd_valid) |-> !core_en);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rnd_valid && !seed_any) |=> $stable(rnd_data));

endmodule

// File: tb/rnd_src_tb.sv
module rnd_src_top_tb_top;

    localparam int STEPS = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        feed_valid, feed_is_seed;
    logic [31:0] feed_data;
    logic        rnd_req, rnd_ack;
    logic        rnd_valid;
    logic [63:0] rnd_data;
    logic        core_en;
    logic        ctl_start, ctl_busy, ctl_done, core_start, core_done;

    int n_run  = 0;
    int n_fail = 0;

    logic [127:0] m0, m1;
    logic [63:0]  hist [64];
    int           n_hist = 0;

    always #2 clk = ~clk;

    rnd_src_top #(.RND_STEPS(STEPS), .OUT_W(32)) dut_i (
        .clk(clk), .rst(rst),
        .feed_valid(feed_valid), .feed_is_seed(feed_is_seed), .feed_data(feed_data),
        .rnd_req(rnd_req), .rnd_ack(rnd_ack), .rnd_valid(rnd_valid), .rnd_data(rnd_data),
        .core_en(core_en), .ctl_start(ctl_start), .ctl_busy(ctl_busy), .ctl_done(ctl_done),
        .core_start(core_start), .core_done(core_done)
    );

    function automatic logic [127:0] mstep(input logic [127:0] s);
        logic b;
        b = 1'b1 ^ s[127] ^ s[125] ^ s[100] ^ s[98];
        return {s[126:0], b};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic seed_all(input logic [127:0] s0, input logic [127:0] s1);
        for (int k = 0; k < 8; k++) begin
            feed_valid   = 1'b1;
            feed_is_seed = 1'b1;
            feed_data    = (k < 4) ? s0[32*k +: 32] : s1[32*(k-4) +: 32];
            tick();
        end
        feed_valid = 1'b0;
        m0 = s0;
        m1 = s1;
    endtask

    // request one word, verify stall length, data, hold and acknowledge
    task automatic fetch(input string tag);
        int n;
        logic [63:0] w;
        rnd_req = 1'b1;
        #0;
        chk(core_en == 1'b0, "R7 stall on request", {63'd0, core_en}, 64'd0);
        n = 0;
        while (!rnd_valid && n < 50) begin
            tick();
            n++;
            if (!rnd_valid)
                chk(core_en == 1'b0, "R7 stall held", {63'd0, core_en}, 64'd0);
        end
        chk(n == STEPS, {"R6 valid latency ", tag}, 64'(n), 64'(STEPS));
        chk(core_en == 1'b1, "R7 enable when ready", {63'd0, core_en}, 64'd1);
        for (int i = 0; i < STEPS; i++) begin
            m0 = mstep(m0);
            m1 = mstep(m1);
        end
        chk(rnd_data == {m1[31:0], m0[31:0]}, {"R9 R2 data ", tag}, rnd_data, {m1[31:0], m0[31:0]});
        w = rnd_data;
        for (int i = 0; i < n_hist; i++)
            chk(hist[i] != w, "R8 word reused", w, hist[i]);
        if (n_hist < 64) begin
            hist[n_hist] = w;
            n_hist++;
        end
        tick();
        tick();
        chk(rnd_valid && rnd_data == w, "R8 hold without ack", rnd_data, w);
        rnd_ack = 1'b1;
        rnd_req = 1'b0;
        tick();
        rnd_ack = 1'b0;
        chk(rnd_valid == 1'b0, "R8 ack clears valid", {63'd0, rnd_valid}, 64'd0);
    endtask

    task automatic t_reset();
        chk(rnd_valid == 1'b0, "R1 valid", {63'd0, rnd_valid}, 64'd0);
        chk(core_en == 1'b1, "R1 core_en", {63'd0, core_en}, 64'd1);
        chk(!ctl_busy && !core_start && !ctl_done, "R1 handshake",
            {61'd0, ctl_busy, core_start, ctl_done}, 64'd0);
        chk(rnd_data == 64'd0, "R1 data", rnd_data, 64'd0);
    endtask

    task automatic t_zero_seed();
        m0 = '0;
        m1 = '0;
        fetch("zero");
        chk(rnd_data[0] == 1'b1, "R9 zero state steps to one", {63'd0, rnd_data[0]}, 64'd1);
    endtask

    task automatic t_seeded();
        seed_all({32'h01234567, 32'h89abcdef, 32'hdeadbeef, 32'h0badf00d},
                 {32'hffffffff, 32'h00000000, 32'hc001d00d, 32'h13579bdf});
        chk(rnd_valid == 1'b0, "R4 no valid after seed", {63'd0, rnd_valid}, 64'd0);
        chk(rnd_data == {m1[31:0], m0[31:0]}, "R2 seed lanes", rnd_data, {m1[31:0], m0[31:0]});
        fetch("seeded a");
        fetch("seeded b");
        fetch("seeded c");
    endtask

    task automatic t_idle();
        logic [63:0] w;
        w = rnd_data;
        for (int i = 0; i < 10; i++) tick();
        chk(rnd_data == w, "R5 idle hold", rnd_data, w);
        chk(core_en == 1'b1, "R7 idle enable", {63'd0, core_en}, 64'd1);
    endtask

    task automatic t_nonseed();
        for (int k = 0; k < 5; k++) begin
            feed_valid   = 1'b1;
            feed_is_seed = 1'b0;
            feed_data    = 32'h5a5a0000 + 32'(k);
            tick();
        end
        feed_valid = 1'b0;
        chk(rnd_data == {m1[31:0], m0[31:0]}, "R3 non-seed ignored", rnd_data, {m1[31:0], m0[31:0]});
        fetch("after non-seed");
        // seed count must still be aligned: a full reseed lands in the right lanes
        seed_all({4{32'h2468ace0}}, {4{32'h1f2e3d4c}});
        chk(rnd_data == {32'h1f2e3d4c, 32'h2468ace0}, "R3 seed count unchanged",
            rnd_data, {32'h1f2e3d4c, 32'h2468ace0});
        fetch("after reseed");
    endtask

    task automatic t_seed_mid_stall();
        int n;
        rnd_req = 1'b1;
        tick();
        tick();
        seed_all({32'h11112222, 32'h33334444, 32'h55556666, 32'h77778888},
                 {32'h9999aaaa, 32'hbbbbcccc, 32'hddddeeee, 32'h0f0f0f0f});
        chk(rnd_valid == 1'b0, "R4 seed during stall", {63'd0, rnd_valid}, 64'd0);
        n = 0;
        while (!rnd_valid && n < 50) begin
            tick();
            n++;
        end
        chk(n == STEPS, "R4 count restarts after seed", 64'(n), 64'(STEPS));
        for (int i = 0; i < STEPS; i++) begin
            m0 = mstep(m0);
            m1 = mstep(m1);
        end
        chk(rnd_data == {m1[31:0], m0[31:0]}, "R4 data from new seed", rnd_data, {m1[31:0], m0[31:0]});
        // seed word while a word is on offer withdraws it
        feed_valid = 1'b1;
        feed_is_seed = 1'b1;
        for (int k = 0; k < 8; k++) begin
            feed_data = 32'hace00000 + 32'(k);
            if (k < 4) m0[32*k +: 32] = feed_data; else m1[32*(k-4) +: 32] = feed_data;
            tick();
            if (k == 0)
                chk(rnd_valid == 1'b0, "R4 seed withdraws word", {63'd0, rnd_valid}, 64'd0);
        end
        feed_valid = 1'b0;
        rnd_req = 1'b0;
        tick();
        fetch("after withdraw");
    endtask

    task automatic t_handshake();
        ctl_start = 1'b1;
        tick();
        ctl_start = 1'b0;
        chk(core_start && ctl_busy, "R10 start passes", {62'd0, core_start, ctl_busy}, 64'd3);
        tick();
        chk(!core_start && ctl_busy, "R10 start is a pulse", {62'd0, core_start, ctl_busy}, 64'd1);
        ctl_start = 1'b1;
        tick();
        ctl_start = 1'b0;
        chk(!core_start, "R10 start while busy ignored", {63'd0, core_start}, 64'd0);
        core_done = 1'b1;
        #0;
        chk(ctl_done == 1'b1, "R10 done passes", {63'd0, ctl_done}, 64'd1);
        tick();
        core_done = 1'b0;
        #0;
        chk(!ctl_busy && !ctl_done, "R10 done clears busy", {62'd0, ctl_busy, ctl_done}, 64'd0);
        core_done = 1'b1;
        #0;
        chk(ctl_done == 1'b0, "R10 done while idle", {63'd0, ctl_done}, 64'd0);
        tick();
        core_done = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        n_run++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        feed_valid = 1'b0; feed_is_seed = 1'b0; feed_data = '0;
        rnd_req = 1'b0; rnd_ack = 1'b0;
        ctl_start = 1'b0; core_done = 1'b0;
        m0 = '0; m1 = '0;
        tick();
        tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_zero_seed();
        t_seeded();
        t_idle();
        t_nonseed();
        t_seed_mid_stall();
        t_handshake();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule